// File: doc/BRIEF.md
# Mode-Dependent Receive Strobe Generator

This block runs on a receiver's bit-rate clock and keeps a position counter that walks through every bit slot of the encoded symbol. The symbol length depends on a width-mode input: a shorter symbol carries 8-bit payloads, and longer ones carry 9-bit or 10-bit payloads. From the position it derives a byte-rate clock and one strobe pulse per symbol. The pulse always starts at the same bit slot. A symbol-type input steers the pulse to either a command strobe or a data strobe.

A resync input pulls the symbol boundary back to position 0 so that it matches the incoming stream. If a strobe is high when a resync arrives, that strobe stays high with no glitch and merges into the window of the realigned symbol. The stretch this causes is capped. A strobe is never cut short.

The strobe machine has three states. `ST_IDLE` leaves both strobes low. It moves to `ST_PULSE` on the edge that leaves position 1 with no resync, and at that point it latches the width and the steering. `ST_PULSE` counts the high cycles and returns to `ST_IDLE` once the nominal width is reached. A resync seen in `ST_PULSE` moves it to `ST_HOLD`. `ST_HOLD` keeps the same strobe high and returns to `ST_IDLE` in either of two cases: the realigned window ends, or the total high time reaches the nominal width plus the stretch cap. A further resync in `ST_HOLD` keeps the machine in `ST_HOLD`.

Top module: `rxstb_gen`

## Requirements
- R1: `sym_pos` counts 0, 1, … up to length−1 and then wraps to 0. The length comes from the latched mode: `mode_sel`=2'b00 gives 10, 2'b01 gives 11, and 2'b10 or 2'b11 gives 12.
- R2: `byte_clk` is high while `sym_pos` is below floor(length/2) and low for the remaining positions, so an odd length puts its extra cycle in the low phase.
- R3: The strobe is first high in the cycle where `sym_pos`=2. It stays high for 4 cycles in mode 2'b00 and for 5 cycles in the other modes.
- R4: When `cmd_sel`=1 the pulse appears on `cmd_stb`; when it is 0 the pulse appears on `dat_stb`. Each symbol has exactly one pulse, and the two strobes are never high together.
- R5: `mode_sel` and `cmd_sel` are captured on the edge that leaves position 0. Changes to them at any other point in the symbol have no effect until the next symbol.
- R6: A resync sampled high on an edge sets `sym_pos` to 0 after that edge.
- R7: If a strobe is high when a resync is sampled, the same strobe stays high without a break until the realigned window ends at position 1+width. The total high time is capped at the nominal width plus 5 cycles.
- R8: If both strobes are low when a resync is sampled, the interrupted symbol produces no pulse. The realigned symbol then produces a normal pulse, steered by its own latched `cmd_sel`.
- R9: A synchronous reset sets `sym_pos` to 0, drives both strobes low, and selects the 10-cycle length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Width mode, captured at position 0 |
| cmd_sel | input | 1 | 1 = command symbol, 0 = data symbol, captured at position 0 |
| resync | input | 1 | Realign the symbol boundary to position 0 |
| sym_pos | output | 4 | Current bit slot within the symbol |
| byte_clk | output | 1 | Byte-rate clock derived from the position |
| cmd_stb | output | 1 | Command strobe |
| dat_stb | output | 1 | Data strobe |

## Verification
All outputs come straight from registers or from logic fed only by registers. Every result therefore appears in the cycle that follows the edge that sampled its cause. A resync shows `sym_pos`=0 one edge later. Mode and steering inputs set in the position-0 cycle take effect one edge later. The strobe of a symbol is first seen in the cycle that shows position 2. The bench drives inputs and reads outputs 1 ns after each rising edge. At every step it compares `sym_pos`, `byte_clk` and both strobes against values it works out from the position it expects, so any shift by one cycle in placement, width or stretch is caught at the exact slot where it happens.

// File: rtl/rxstb_pkg.sv
package rxstb_pkg;

    localparam int POS_W = 4;

    typedef enum logic [1:0] {
        MODE_B8   = 2'b00,
        MODE_B9   = 2'b01,
        MODE_B10  = 2'b10,
        MODE_B10X = 2'b11
    } width_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_PULSE = 2'b01,
        ST_HOLD  = 2'b10
    } stb_state_e;

    // bit slots per encoded symbol
    function automatic logic [POS_W-1:0] sym_len(width_mode_e m);
        unique case (m)
            MODE_B8: sym_len = POS_W'(10);
            MODE_B9: sym_len = POS_W'(11);
            default: sym_len = POS_W'(12);
        endcase
    endfunction

    // nominal strobe high time in bit slots
    function automatic logic [POS_W-1:0] pulse_w(width_mode_e m);
        pulse_w = (m == MODE_B8) ? POS_W'(4) : POS_W'(5);
    endfunction

endpackage

// File: rtl/rxstb_pos_counter.sv
module rxstb_pos_counter
    import rxstb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             resync,
    input  logic [1:0]       mode_in,
    input  logic             sel_in,
    output logic [POS_W-1:0] pos,
    output width_mode_e      mode_q,
    output logic             sel_q
);

    logic [POS_W-1:0] last_pos;

    assign last_pos = sym_len(mode_q) - POS_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos    <= '0;
            mode_q <= MODE_B8;
            sel_q  <= 1'b0;
        end else begin
            if (pos == '0) begin
                mode_q <= width_mode_e'(mode_in);
                sel_q  <= sel_in;
            end
            if (resync || pos == last_pos) begin
                pos <= '0;
            end else begin
                pos <= pos + POS_W'(1);
            end
        end
    end

endmodule

// File: rtl/rxstb_byte_clk.sv
module rxstb_byte_clk
    import rxstb_pkg::*;
(
    input  logic [POS_W-1:0] pos,
    input  width_mode_e      mode_q,
    output logic             byte_clk
);

    logic [POS_W-1:0] half_len;

    // floor division sends the odd slot to the low phase
    assign half_len = sym_len(mode_q) >> 1;
    assign byte_clk = (pos < half_len);

endmodule

// File: rtl/rxstb_strobe_fsm.sv
module rxstb_strobe_fsm
    import rxstb_pkg::*;
#(
    parameter int START_POS   = 2,
    parameter int STRETCH_MAX = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             resync,
    input  logic [POS_W-1:0] pos,
    input  width_mode_e      mode_q,
    input  logic             sel_q,
    output logic             cmd_stb,
    output logic             dat_stb
);

    localparam logic [POS_W-1:0] ARM_POS = POS_W'(START_POS - 1);
    localparam logic [POS_W-1:0] EXT_CAP = POS_W'(STRETCH_MAX);

    stb_state_e       state_q, state_d;
    logic [POS_W-1:0] hcnt_q, hcnt_d;
    logic [POS_W-1:0] pw_q, pw_d;
    logic             psel_q, psel_d;
    logic             window_end, cap_hit;

    assign window_end = (pos == ARM_POS + pulse_w(mode_q));
    assign cap_hit    = (hcnt_q == pw_q + EXT_CAP);

    always_comb begin
        state_d = state_q;
        hcnt_d  = hcnt_q;
        pw_d    = pw_q;
        psel_d  = psel_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!resync && pos == ARM_POS) begin
                    state_d = ST_PULSE;
                    hcnt_d  = POS_W'(1);
                    pw_d    = pulse_w(mode_q);
                    psel_d  = sel_q;
                end
            end
            ST_PULSE: begin
                if (resync) begin
                    state_d = ST_HOLD;
                    hcnt_d  = hcnt_q + POS_W'(1);
                end else if (hcnt_q == pw_q) begin
                    state_d = ST_IDLE;
                end else begin
                    hcnt_d  = hcnt_q + POS_W'(1);
                end
            end
            ST_HOLD: begin
                if (resync) begin
                    hcnt_d  = hcnt_q + POS_W'(1);
                end else if (cap_hit || window_end) begin
                    state_d = ST_IDLE;
                end else begin
                    hcnt_d  = hcnt_q + POS_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            hcnt_q  <= '0;
            pw_q    <= '0;
            psel_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            hcnt_q  <= hcnt_d;
            pw_q    <= pw_d;
            psel_q  <= psel_d;
        end
    end

    always_comb begin
        cmd_stb = (state_q != ST_IDLE) &&  psel_q;
        dat_stb = (state_q != ST_IDLE) && !psel_q;
    end

endmodule

// File: rtl/rxstb_gen.sv
module rxstb_gen
    import rxstb_pkg::*;
#(
    parameter int START_POS   = 2,
    parameter int STRETCH_MAX = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic             cmd_sel,
    input  logic             resync,
    output logic [POS_W-1:0] sym_pos,
    output logic             byte_clk,
    output logic             cmd_stb,
    output logic             dat_stb
);

    width_mode_e mode_q;
    logic        sel_q;

    rxstb_pos_counter u_pos (
        .clk     (clk),
        .rst     (rst),
        .resync  (resync),
        .mode_in (mode_sel),
        .sel_in  (cmd_sel),
        .pos     (sym_pos),
        .mode_q  (mode_q),
        .sel_q   (sel_q)
    );

    rxstb_byte_clk u_bclk (
        .pos      (sym_pos),
        .mode_q   (mode_q),
        .byte_clk (byte_clk)
    );

    rxstb_strobe_fsm #(
        .START_POS   (START_POS),
        .STRETCH_MAX (STRETCH_MAX)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .resync  (resync),
        .pos     (sym_pos),
        .mode_q  (mode_q),
        .sel_q   (sel_q),
        .cmd_stb (cmd_stb),
        .dat_stb (dat_stb)
    );

endmodule

// File: rtl/rxstb_checks.sv
module rxstb_checks (
    input logic       clk,
    input logic       rst,
    input logic       resync,
    input logic [3:0] sym_pos,
    input logic       cmd_stb,
    input logic       dat_stb
);

    logic [3:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
        end else if (cmd_stb || dat_stb) begin
            if (hi_run != 4'hF) hi_run <= hi_run + 4'd1;
        end else begin
            hi_run <= '0;
        end
    end

    p_pos_range_r1: assert property (@(posedge clk) disable iff (rst)
        sym_pos < 4'd12);

    p_rise_at_slot2_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_stb || dat_stb) |-> sym_pos == 4'd2);

    p_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        !(cmd_stb && dat_stb));

    p_resync_zero_r6: assert property (@(posedge clk) disable iff (rst)
        resync |=> sym_pos == 4'd0);

    p_cmd_no_swap_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |=> !dat_stb);

    p_dat_no_swap_r7: assert property (@(posedge clk) disable iff (rst)
        dat_stb |=> !cmd_stb);

    // at most 5 nominal + 5 stretch cycles high in a row
    p_stretch_cap_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb || dat_stb) |-> hi_run < 4'd10);

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (sym_pos == 4'd0 && !cmd_stb && !dat_stb));

endmodule

bind rxstb_gen rxstb_checks u_rxstb_checks (
    .clk     (clk),
    .rst     (rst),
    .resync  (resync),
    .sym_pos (sym_pos),
    .cmd_stb (cmd_stb),
    .dat_stb (dat_stb)
);

// File: tb/test_rxstb_gen.sv
`timescale 1ns/1ps
module test_rxstb_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic       cmd_sel = 1'b0;
    logic       resync = 1'b0;
    logic [3:0] sym_pos;
    logic       byte_clk;
    logic       cmd_stb;
    logic       dat_stb;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    rxstb_gen i_rxstb_gen (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .cmd_sel  (cmd_sel),
        .resync   (resync),
        .sym_pos  (sym_pos),
        .byte_clk (byte_clk),
        .cmd_stb  (cmd_stb),
        .dat_stb  (dat_stb)
    );

    function automatic int len_of(logic [1:0] m);
        return (m == 2'b00) ? 10 : (m == 2'b01) ? 11 : 12;
    endfunction

    function automatic int w_of(logic [1:0] m);
        return (m == 2'b00) ? 4 : 5;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R9: reset from any point clears position and strobes
    task automatic t_reset(int pre_ticks);
        repeat (pre_ticks) tick();
        rst = 1'b1;
        repeat (2) tick();
        chk("R9", "sym_pos in reset", int'(sym_pos), 0);
        chk("R9", "cmd_stb in reset", int'(cmd_stb), 0);
        chk("R9", "dat_stb in reset", int'(dat_stb), 0);
        rst = 1'b0;
    endtask

    // one full symbol from position 0; optional input disturbance mid-symbol (R5)
    task automatic t_symbol(logic [1:0] m, logic s, bit disturb);
        int len = len_of(m);
        int w   = w_of(m);
        string tag = disturb ? "R5" : "R3";
        mode_sel = m;
        cmd_sel  = s;
        for (int k = 0; k < len; k++) begin
            bit hi = (k >= 2) && (k <= 1 + w);
            chk(disturb ? "R5" : "R1", "sym_pos", int'(sym_pos), k);
            chk("R2", "byte_clk", int'(byte_clk), (k < len / 2) ? 1 : 0);
            chk(tag, "cmd_stb R4", int'(cmd_stb), (hi && s) ? 1 : 0);
            chk(tag, "dat_stb R4", int'(dat_stb), (hi && !s) ? 1 : 0);
            if (disturb && k == 3) begin
                mode_sel = (m == 2'b00) ? 2'b01 : 2'b00;
                cmd_sel  = !s;
            end
            tick();
        end
        chk(disturb ? "R5" : "R1", "sym_pos after wrap", int'(sym_pos), 0);
    endtask

    // resync sampled on the edge leaving position at_k
    task automatic t_resync(logic [1:0] m, logic s, int at_k);
        int len = len_of(m);
        int w   = w_of(m);
        bit hi_now = (at_k >= 2) && (at_k <= 1 + w);
        int h0 = at_k - 1;
        int total = (h0 + w + 2 < w + 5) ? h0 + w + 2 : w + 5;
        mode_sel = m;
        cmd_sel  = s;
        for (int k = 0; k < at_k; k++) tick();
        chk("R6", "sym_pos before resync", int'(sym_pos), at_k);
        resync = 1'b1;
        tick();
        resync  = 1'b0;
        cmd_sel = !s;
        chk("R6", "sym_pos after resync", int'(sym_pos), 0);
        for (int p = 0; p < len; p++) begin
            if (hi_now) begin
                bit hi = (h0 + 1 + p) <= total;
                chk("R7", "held cmd_stb", int'(cmd_stb), (hi && s) ? 1 : 0);
                chk("R7", "held dat_stb", int'(dat_stb), (hi && !s) ? 1 : 0);
            end else begin
                bit hi = (p >= 2) && (p <= 1 + w);
                chk("R8", "realigned cmd_stb", int'(cmd_stb), (hi && !s) ? 1 : 0);
                chk("R8", "realigned dat_stb", int'(dat_stb), (hi && s) ? 1 : 0);
            end
            chk("R6", "sym_pos realigned", int'(sym_pos), p);
            tick();
        end
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset(0);
        t_symbol(2'b00, 1'b1, 1'b0);
        t_symbol(2'b01, 1'b0, 1'b0);
        t_symbol(2'b10, 1'b1, 1'b0);
        t_symbol(2'b11, 1'b0, 1'b0);
        t_symbol(2'b00, 1'b0, 1'b1);
        t_symbol(2'b10, 1'b1, 1'b1);
        t_resync(2'b00, 1'b1, 2);   // stretch by 3, ends at window
        t_resync(2'b00, 1'b0, 5);   // stretch capped at +5
        t_resync(2'b01, 1'b1, 3);   // mode 01 window end
        t_resync(2'b10, 1'b0, 6);   // last high slot, capped
        t_resync(2'b00, 1'b1, 8);   // low strobe, new pulse R8
        t_resync(2'b01, 1'b0, 1);   // just before start, no pulse R8
        t_symbol(2'b00, 1'b1, 1'b0);
        mode_sel = 2'b00;
        cmd_sel  = 1'b1;
        t_reset(4);                 // reset while strobe high
        t_symbol(2'b01, 1'b1, 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule